// File: doc/BRIEF.md
# UART Register Front-End on APB

This block is the processor-facing side of a UART. It sits on an APB bus as a slave with a 20-byte register window. It connects to a byte-wide receive stream coming in and a byte-wide transmit stream going out. Serial framing and baud generation belong to a separate block. Bytes offered on the receive stream are queued in a circular FIFO. Software drains the FIFO by reading the data register, and each such read removes the byte it returns. A write to the data register sends the low byte of the write data out as a single-cycle transmit beat.

The block also holds a read-only status word, whose flags follow the FIFO occupancy and the transmit activity, and a 32-bit control word that software can read and write. When the receive-interrupt enable in the control word is set, each byte stored in the FIFO produces a one-cycle interrupt pulse. Every transfer completes with no wait states. Only the low eight address bits are decoded, so the window repeats throughout the address space.

Top module: `uart_apb_frontend`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0, so every transfer takes exactly a setup cycle and an access cycle.
- R2: An access-phase read at byte offset 0x00, or at its alias 0x03, returns the oldest queued byte in bits 7:0 with zeros above it, and removes that byte from the FIFO. Bytes come out in the order they were accepted.
- R3: A data read while the FIFO is empty returns 0, leaves the FIFO empty, and leaves status bit 0 at 0.
- R4: An access-phase write at offset 0x00 or 0x03 drives `tx_valid` high for exactly the one cycle after the access, with `tx_data` equal to `pwdata[7:0]`.
- R5: An access-phase write at offset 0x08 stores all 32 bits of `pwdata` in the control word. A read at 0x08 returns the last value written, and 0 after reset.
- R6: The status word read at 0x04 is laid out as follows. Bit 0 is 1 when the FIFO is not empty. Bits 1 and 2 are 1 while `tx_valid` is low. Bit 8 is 1 when the FIFO holds at least half its depth. Bit 10 is 1 when the FIFO is full. All other bits are 0.
- R7: Writes at 0x04, 0x0C, 0x10 or any unmapped offset change neither the control word, the status word nor the FIFO contents. Reads at 0x0C, 0x10 and unmapped offsets return 0.
- R8: Only `paddr[7:0]` is decoded. For example, an address of 0x108 reaches the control word.
- R9: `rx_ready` is 0 exactly when the FIFO holds RX_DEPTH bytes (16 by default). A byte is stored only on a cycle where `rx_valid` and `rx_ready` are both 1, so no byte is dropped.
- R10: When control bit 2 is 1, `irq` is high for the one cycle after each stored byte. When control bit 2 is 0, `irq` stays low.
- R11: A data-register read that never reaches the access phase (psel high with penable low, then dropped) does not remove any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Transmit byte beat |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Receive interrupt pulse |

## Verification
A FIFO pointer or count that drifts from its true value shows up on the very next data read, as a wrong or out-of-order byte. It also shows up in the next status read, as a wrong data-ready, half or full flag, or as `rx_ready` falling too early or too late. A wrong decode shows up in the access cycle itself, either as prdata from the wrong register or as a lost byte. A control word that fails to hold shows up at the following control read-back, and in whether `irq` pulses one cycle after the next stored byte.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam logic [7:0] OFF_DATA    = 8'h00;
  localparam logic [7:0] OFF_DATA_B3 = 8'h03;
  localparam logic [7:0] OFF_STAT    = 8'h04;
  localparam logic [7:0] OFF_CTRL    = 8'h08;
  localparam logic [7:0] OFF_SCALE   = 8'h0C;
  localparam logic [7:0] OFF_DBG     = 8'h10;

  localparam int ST_READY    = 0;
  localparam int ST_SH_EMPTY = 1;
  localparam int ST_TQ_EMPTY = 2;
  localparam int ST_RX_HALF  = 8;
  localparam int ST_RX_FULL  = 10;

  localparam int CT_RX_IRQ_EN = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_SCALE, SEL_DBG
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    case (off)
      OFF_DATA, OFF_DATA_B3: return SEL_DATA;
      OFF_STAT:              return SEL_STAT;
      OFF_CTRL:              return SEL_CTRL;
      OFF_SCALE:             return SEL_SCALE;
      OFF_DBG:               return SEL_DBG;
      default:               return SEL_NONE;
    endcase
  endfunction

  function automatic logic [31:0] pack_status(input logic ready, input logic tx_idle,
                                              input logic half, input logic full);
    logic [31:0] s;
    s = '0;
    s[ST_READY]    = ready;
    s[ST_SH_EMPTY] = tx_idle;
    s[ST_TQ_EMPTY] = tx_idle;
    s[ST_RX_HALF]  = half;
    s[ST_RX_FULL]  = full;
    return s;
  endfunction

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
  import uart_fe_pkg::*;
(
  input  logic       psel,
  input  logic       penable,
  input  logic       pwrite,
  input  logic [7:0] off,
  output reg_sel_e   sel,
  output logic       data_rd,
  output logic       data_wr,
  output logic       ctrl_wr
);
  logic access;

  assign sel     = decode_off(off);
  assign access  = psel && penable;
  assign data_rd = access && !pwrite && (sel == SEL_DATA);
  assign data_wr = access &&  pwrite && (sel == SEL_DATA);
  assign ctrl_wr = access &&  pwrite && (sel == SEL_CTRL);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'((DEPTH + 1) / 2);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CNT_W-1:0] count;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty = (count == '0);
  assign full  = (count == CNT_FULL);
  assign half  = (count >= CNT_HALF);
  assign rdata = empty ? '0 : mem[rd_ptr];

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);
  assert_pop_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));
  assert_push_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/uart_tx_beat.sv
module uart_tx_beat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send,
  input  logic [7:0] byte_in,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= send;
      if (send) tx_data <= byte_in;
    end
  end
endmodule

// File: rtl/uart_apb_frontend.sv
module uart_apb_frontend
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  reg_sel_e    sel;
  logic        data_rd, data_wr, ctrl_wr;
  logic        rx_push, rx_pop;
  logic [7:0]  fifo_head;
  logic        fifo_empty, fifo_full, fifo_half;
  logic [31:0] ctrl_q, status_w;

  uart_fe_decode u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .off(paddr[7:0]),
    .sel(sel), .data_rd(data_rd), .data_wr(data_wr), .ctrl_wr(ctrl_wr)
  );

  assign rx_ready = !fifo_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = data_rd && !fifo_empty;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_data), .pop(rx_pop),
    .rdata(fifo_head), .empty(fifo_empty), .full(fifo_full), .half(fifo_half)
  );

  uart_tx_beat u_tx (
    .clk(clk), .rst_n(rst_n), .send(data_wr), .byte_in(pwdata[7:0]),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= pwdata;
      irq <= rx_push && ctrl_q[CT_RX_IRQ_EN];
    end
  end

  assign status_w = pack_status(!fifo_empty, !tx_valid, fifo_half, fifo_full);

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        SEL_DATA: prdata = {24'b0, fifo_head};
        SEL_STAT: prdata = status_w;
        SEL_CTRL: prdata = ctrl_q;
        default:  prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assert_zero_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);
  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_empty) |-> (prdata == 32'b0));
  assert_tx_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(psel && penable && pwrite));
  assert_irq_after_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid && rx_ready));
  assert_ready_when_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> rx_ready);
  assert_no_pop_setup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && !rx_push) |=> $stable(fifo_empty));
endmodule

// File: tb/tb_uart_apb_frontend.sv
module tb_uart_apb_frontend;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid, irq;
  logic [7:0] tx_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  byte unsigned q[$];
  logic [31:0] ctrl_m = '0;
  logic last_txv;
  logic [7:0] last_txd;

  always #2 clk = ~clk;

  uart_apb_frontend dut (.*);

  function automatic logic [31:0] exp_status(int n);
    logic [31:0] s = '0;
    s[0] = (n != 0); s[1] = 1'b1; s[2] = 1'b1;
    s[8] = (n >= DEPTH / 2); s[10] = (n == DEPTH);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1;
    d = prdata;
    chk(pready === 1'b1 && pslverr === 1'b0, "R1", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    last_txv = tx_valid; last_txd = tx_data;
  endtask

  task automatic push(input byte unsigned b);
    bit ok;
    @(negedge clk); rx_valid = 1; rx_data = b; #1; ok = rx_ready;
    chk(ok == (q.size() < DEPTH), "R9 rx_ready", {31'b0, ok}, {31'b0, q.size() < DEPTH});
    @(negedge clk); rx_valid = 0;
    if (ok) q.push_back(b);
    chk(irq === (ok & ctrl_m[2]), "R10 irq pulse", {31'b0, irq}, {31'b0, ok & ctrl_m[2]});
    @(negedge clk);
    chk(irq === 1'b0, "R10 irq one cycle", {31'b0, irq}, 32'h0);
  endtask

  task automatic read_data(input logic [11:0] a);
    logic [31:0] d, e;
    e = (q.size() != 0) ? {24'b0, q[0]} : 32'h0;
    apb_rd(a, d);
    if (q.size() != 0) void'(q.pop_front());
    chk(d === e, (e == 0) ? "R3 empty read" : "R2 fifo order", d, e);
  endtask

  task automatic read_status();
    logic [31:0] d;
    apb_rd(12'h004, d);
    chk(d === exp_status(q.size()), "R6 status", d, exp_status(q.size()));
  endtask

  task automatic read_ctrl(input logic [11:0] a);
    logic [31:0] d;
    apb_rd(a, d);
    chk(d === ctrl_m, "R5 ctrl", d, ctrl_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    read_status();
    read_ctrl(12'h008);
    chk(tx_valid === 1'b0 && irq === 1'b0, "R4 R10 reset", {30'b0, tx_valid, irq}, 32'h0);
    // R3: empty data read
    read_data(12'h000);
    read_status();
    // R10: irq enabled, fill to full
    ctrl_m = 32'h0000_0004; apb_wr(12'h008, ctrl_m);
    for (int i = 0; i < DEPTH; i++) push(8'(i * 7 + 1));
    read_status();
    push(8'hEE); // R9 refused when full
    read_status();
    // R11: setup-only data read does not pop
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h000;
    @(negedge clk); psel = 0;
    read_status();
    // R2 alias at offset 3
    read_data(12'h003);
    read_data(12'h000);
    // R7: ignored writes and zero reads
    apb_wr(12'h004, 32'hFFFF_FFFF);
    apb_wr(12'h00C, 32'hFFFF_FFFF);
    apb_wr(12'h010, 32'hFFFF_FFFF);
    apb_wr(12'h040, 32'hFFFF_FFFF);
    chk(last_txv === 1'b0, "R7 no tx", {31'b0, last_txv}, 32'h0);
    read_ctrl(12'h008);
    read_status();
    apb_rd(12'h00C, d); chk(d === 0, "R7 scaler read", d, 0);
    apb_rd(12'h010, d); chk(d === 0, "R7 debug read", d, 0);
    apb_rd(12'h044, d); chk(d === 0, "R7 unmapped read", d, 0);
    // R8: high address bits ignored
    ctrl_m = 32'hA5A5_1F0B; apb_wr(12'h508, ctrl_m);
    read_ctrl(12'h108);
    apb_rd(12'hF04, d); chk(d === exp_status(q.size()), "R8 status alias", d, exp_status(q.size()));
    // R4: transmit beat, both offsets
    apb_wr(12'h000, 32'h1234_56C3);
    chk(last_txv === 1'b1 && last_txd === 8'hC3, "R4 tx beat", {23'b0, last_txv, last_txd}, 32'h1C3);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R4 tx one cycle", {31'b0, tx_valid}, 32'h0);
    apb_wr(12'h003, 32'h0000_005A);
    chk(last_txv === 1'b1 && last_txd === 8'h5A, "R4 tx alias", {23'b0, last_txv, last_txd}, 32'h15A);
    // drain
    while (q.size() != 0) read_data(12'h000);
    read_data(12'h000);
    read_status();
    // random mix
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 6)
        0, 1: push(8'($urandom));
        2:    read_data(($urandom % 2) ? 12'h003 : 12'h000);
        3:    read_status();
        4: begin
          ctrl_m = $urandom; apb_wr(12'h008, ctrl_m); read_ctrl(12'h008);
        end
        default: begin
          logic [7:0] b = 8'($urandom);
          apb_wr(12'h000, {24'h0, b});
          chk(last_txv === 1'b1 && last_txd === b, "R4 tx random", {23'b0, last_txv, last_txd}, {23'b0, 1'b1, b});
        end
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule